// File: doc/BRIEF.md
# Energy Pulse Output Shaper

The shaper converts single-cycle pulse requests from a metering computation engine into width-limited output pulses. It has two independent channels: one for real power and one for reactive power. All time is measured in sample ticks. A sample tick is a one-cycle strobe at the measurement sample rate, delivered on the system clock.

The block has two operating modes, selected by the pacing interval.

- **Direct mode (interval = 0):** each request starts a pulse on the next clock edge.
- **Paced mode (interval > 0):** requests wait in a small per-channel queue. They are released one at a time, and only on interval boundaries.

A width setting caps each pulse at an odd number of time units. The all-ones value of the width setting removes the cap. In that case each pulse lasts half the sample-tick distance since the previous pulse on the same channel. A polarity input flips both outputs from active low to active high.

Top module: `energy_pulse_shaper`

## Requirements
- R1: After reset, both pulse outputs are inactive (high when `cfg_invert` = 0) and both overflow flags read 0.
- R2: With `cfg_interval` = 0 and `cfg_maxw` = W < 255, a request to an idle channel makes its output active from the next clock edge. The pulse stays active for exactly 2W+1 sample ticks.
- R3: With `cfg_invert` = 1, the active level of both outputs is high; with 0 it is low.
- R4: With `cfg_interval` = I > 0, a pulse begins only on a clock edge that carries a sample tick closing an I-tick interval. Its length is (2W+1)·I sample ticks.
- R5: In paced mode, each channel holds up to 4 pending requests. They are released in order, at most one per boundary. A pulse never starts while the previous one on that channel is still active.
- R6: A request is dropped and its channel's overflow flag is set in two cases: the queue already holds 4 requests (paced mode), or a pulse is active (direct mode). The flag stays set until reset.
- R7: With `cfg_maxw` = 255, a pulse lasts max(⌊G/2⌋, 1) sample ticks. G is the number of sample ticks between this pulse's start edge and the previous start on the same channel, both start edges excluded.
- R8: The two channels are independent: a request on one never activates the other output or sets the other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle strobe per measurement sample |
| req_real | input | 1 | Real-power pulse request (one cycle) |
| req_react | input | 1 | Reactive-power pulse request (one cycle) |
| cfg_maxw | input | 8 | Width cap W; pulse ≤ 2W+1 units; 255 = no cap |
| cfg_interval | input | 8 | Pacing interval in sample ticks; 0 = direct mode |
| cfg_invert | input | 1 | 1 = outputs active high |
| pulse_real | output | 1 | Real-power pulse output |
| pulse_react | output | 1 | Reactive-power pulse output |
| ovf_real | output | 1 | Sticky overflow flag, real channel |
| ovf_react | output | 1 | Sticky overflow flag, reactive channel |

## Verification
Each state fault shows up at the ports, and each is caught by a test that finishes within a few intervals.

- **Pulse-length counter fault:** the output stays active for a wrong number of sample ticks, visible when the pulse ends.
- **Pacing counter fault:** a pulse starts on a clock edge that closes no interval, or its length is not a multiple of I.
- **Queue count fault:** a pulse is lost, or an extra pulse appears, after a burst. The flag may also rise too early or not at all.
- **Gap counter fault:** in the uncapped mode, the second pulse after a known tick distance has the wrong length.

// File: rtl/epo_pkg.sv
package epo_pkg;
    localparam int NUM_CH = 2;
    typedef enum logic [0:0] {
        CH_REAL  = 1'b0,
        CH_REACT = 1'b1
    } chan_e;
endpackage

// File: rtl/epo_pacer.sv
module epo_pacer #(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_tick,
    input  logic [IVL_W-1:0] cfg_interval,
    output logic             paced,
    output logic             unit_tick
);
    typedef struct packed {
        logic [IVL_W-1:0] cnt;
    } pacer_t;

    pacer_t s_d, s_q;
    logic   wrap;

    always_comb begin
        s_d       = s_q;
        paced     = (cfg_interval != '0);
        wrap      = (s_q.cnt >= cfg_interval - 1'b1);
        unit_tick = paced ? (sample_tick && wrap) : sample_tick;
        if (!paced) begin
            s_d.cnt = '0;
        end else if (sample_tick) begin
            s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/epo_channel.sv
module epo_channel #(
    parameter int MAXW_W = 8,
    parameter int DEPTH  = 4,
    parameter int GAP_W  = 16,
    localparam int PW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              unit_tick,
    input  logic              paced,
    input  logic [MAXW_W-1:0] cfg_maxw,
    input  logic              req,
    output logic              active,
    output logic              ovf,
    output logic [PW-1:0]     pend
);
    typedef struct packed {
        logic             act;
        logic             ovf;
        logic [PW-1:0]    pend;
        logic [GAP_W-1:0] run;
        logic [GAP_W-1:0] tgt;
        logic [GAP_W-1:0] gap;
    } chan_t;

    chan_t            s_d, s_q;
    logic             uncapped, step, ending, start, full, drop;
    logic [GAP_W-1:0] limit, half, run_nx;

    always_comb begin
        s_d      = s_q;
        uncapped = (cfg_maxw == '1);
        step     = uncapped ? sample_tick : unit_tick;
        limit    = uncapped ? s_q.tgt
                            : {{(GAP_W-MAXW_W-1){1'b0}}, cfg_maxw, 1'b1};
        run_nx   = s_q.run + 1'b1;
        ending   = s_q.act && step && (run_nx >= limit);
        full     = (s_q.pend == PW'(DEPTH));
        half     = s_q.gap >> 1;

        if (paced) start = unit_tick && (s_q.pend != '0) && !s_q.act;
        else       start = req && !s_q.act;

        if (paced) drop = req && full && !start;
        else       drop = req && s_q.act;

        if (sample_tick && (s_q.gap != '1)) s_d.gap = s_q.gap + 1'b1;

        if (s_q.act && step) begin
            s_d.run = run_nx;
            if (ending) s_d.act = 1'b0;
        end

        if (start) begin
            s_d.act = 1'b1;
            s_d.run = '0;
            s_d.gap = '0;
            s_d.tgt = (half == '0) ? GAP_W'(1) : half;
        end

        if (!paced) begin
            s_d.pend = '0;
        end else begin
            s_d.pend = s_q.pend + PW'(req && !drop) - PW'(start);
        end

        if (drop) s_d.ovf = 1'b1;

        active = s_q.act;
        ovf    = s_q.ovf;
        pend   = s_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/energy_pulse_shaper.sv
module energy_pulse_shaper #(
    parameter int MAXW_W = 8,
    parameter int IVL_W  = 8,
    parameter int DEPTH  = 4,
    parameter int GAP_W  = 16,
    localparam int PW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              req_real,
    input  logic              req_react,
    input  logic [MAXW_W-1:0] cfg_maxw,
    input  logic [IVL_W-1:0]  cfg_interval,
    input  logic              cfg_invert,
    output logic              pulse_real,
    output logic              pulse_react,
    output logic              ovf_real,
    output logic              ovf_react
);
    import epo_pkg::*;

    logic                paced, unit_tick;
    logic [NUM_CH-1:0]   req_v, act_v, ovf_v;
    logic [PW-1:0]       pend_w [NUM_CH];

    assign req_v[CH_REAL]  = req_real;
    assign req_v[CH_REACT] = req_react;

    epo_pacer #(.IVL_W(IVL_W)) u_pacer (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_tick  (sample_tick),
        .cfg_interval (cfg_interval),
        .paced        (paced),
        .unit_tick    (unit_tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        epo_channel #(
            .MAXW_W (MAXW_W),
            .DEPTH  (DEPTH),
            .GAP_W  (GAP_W)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .sample_tick (sample_tick),
            .unit_tick   (unit_tick),
            .paced       (paced),
            .cfg_maxw    (cfg_maxw),
            .req         (req_v[c]),
            .active      (act_v[c]),
            .ovf         (ovf_v[c]),
            .pend        (pend_w[c])
        );
    end

    assign pulse_real  = act_v[CH_REAL]  ^ ~cfg_invert;
    assign pulse_react = act_v[CH_REACT] ^ ~cfg_invert;
    assign ovf_real    = ovf_v[CH_REAL];
    assign ovf_react   = ovf_v[CH_REACT];
endmodule

// File: rtl/energy_pulse_shaper_chk.sv
module energy_pulse_shaper_chk #(
    parameter int IVL_W = 8,
    parameter int PW    = 3,
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_tick,
    input logic             req_real,
    input logic             req_react,
    input logic [IVL_W-1:0] cfg_interval,
    input logic             cfg_invert,
    input logic             pulse_real,
    input logic             pulse_react,
    input logic             ovf_real,
    input logic             ovf_react,
    input logic [PW-1:0]    pend_real,
    input logic [PW-1:0]    pend_react
);
    logic act_r, act_x, direct;
    assign act_r  = pulse_real  ^ ~cfg_invert;
    assign act_x  = pulse_react ^ ~cfg_invert;
    assign direct = (cfg_interval == '0);

    // R2: direct-mode start follows a request
    p_direct_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act_r) && $stable(cfg_invert) && direct && $past(direct)) |-> $past(req_real));

    // R4: paced start only on a sample-tick edge
    p_paced_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act_r) && $stable(cfg_invert) && !direct && !$past(direct)) |-> $past(sample_tick));

    // R5: paced start needs a pending request; queue bounded
    p_pending_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act_r) && $stable(cfg_invert) && !direct && !$past(direct)) |-> ($past(pend_real) != '0));
    p_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_real <= PW'(DEPTH)) && (pend_react <= PW'(DEPTH)));

    // R6: overflow sticky and only raised by a request
    p_no_overflow_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_real |=> ovf_real);
    p_ovf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_real) |-> $past(req_real));

    // R8: reactive channel reacts only to its own request
    p_react_own_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act_x) && $stable(cfg_invert) && direct && $past(direct)) |-> $past(req_react));
    p_react_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_react) |-> $past(req_react));
endmodule

bind energy_pulse_shaper energy_pulse_shaper_chk #(
    .IVL_W (IVL_W),
    .PW    (PW),
    .DEPTH (DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_tick  (sample_tick),
    .req_real     (req_real),
    .req_react    (req_react),
    .cfg_interval (cfg_interval),
    .cfg_invert   (cfg_invert),
    .pulse_real   (pulse_real),
    .pulse_react  (pulse_react),
    .ovf_real     (ovf_real),
    .ovf_react    (ovf_react),
    .pend_real    (pend_w[0]),
    .pend_react   (pend_w[1])
);

// File: tb/energy_pulse_shaper_bench.sv
`timescale 1ns/1ps
module energy_pulse_shaper_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       req_real = 1'b0, req_react = 1'b0;
    logic [7:0] cfg_maxw = 8'hFF, cfg_interval = 8'd0;
    logic       cfg_invert = 1'b0;
    logic       pulse_real, pulse_react, ovf_real, ovf_react;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    energy_pulse_shaper u_energy_pulse_shaper (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .req_real(req_real), .req_react(req_react),
        .cfg_maxw(cfg_maxw), .cfg_interval(cfg_interval), .cfg_invert(cfg_invert),
        .pulse_real(pulse_real), .pulse_react(pulse_react),
        .ovf_real(ovf_real), .ovf_react(ovf_react)
    );

    always #2 clk = ~clk;

    // sample tick: one cycle in five, changed just after the rising edge
    initial begin
        int div = 0;
        forever begin
            @(posedge clk); #1;
            div = (div == 4) ? 0 : div + 1;
            sample_tick = (div == 0);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_act(input logic v);
        return v ^ ~cfg_invert;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // counts sample ticks during the next active period of a channel
    task automatic measure(input bit ch, output int n, output bit other_seen);
        bit seen = 0;
        n = 0; other_seen = 0;
        for (int i = 0; i < 6000; i++) begin
            logic a, o;
            a = is_act(ch ? pulse_react : pulse_real);
            o = is_act(ch ? pulse_real : pulse_react);
            if (o) other_seen = 1;
            if (a) begin
                seen = 1;
                if (sample_tick) n++;
            end else if (seen) begin
                return;
            end
            @(negedge clk);
        end
        n = -1;
    endtask

    task automatic fire(input bit ch);
        @(negedge clk);
        if (ch) req_react = 1'b1; else req_real = 1'b1;
        @(negedge clk);
        req_real = 1'b0; req_react = 1'b0;
    endtask

    task automatic t_reset();
        cfg_invert = 0; cfg_maxw = 8'hFF; cfg_interval = 0;
        do_reset();
        check(pulse_real === 1'b1, "R1 pulse_real idle", pulse_real, 1);
        check(pulse_react === 1'b1, "R1 pulse_react idle", pulse_react, 1);
        check(ovf_real === 1'b0 && ovf_react === 1'b0, "R1 ovf clear", ovf_real, 0);
    endtask

    task automatic t_direct();
        int n; bit o;
        cfg_interval = 0; cfg_maxw = 0;
        do_reset();
        fire(0);
        check(is_act(pulse_real), "R2 immediate start", pulse_real, 0);
        measure(0, n, o);
        check(n == 1, "R2 W=0 width", n, 1);
        check(!o, "R8 react untouched", o, 0);
        cfg_maxw = 3;
        fire(1); measure(1, n, o);
        check(n == 7, "R2 W=3 width", n, 7);
        check(!o, "R8 real untouched", o, 0);
    endtask

    task automatic t_polarity();
        int n; bit o;
        cfg_invert = 1; cfg_maxw = 1; cfg_interval = 0;
        do_reset();
        check(pulse_real === 1'b0, "R3 inverted idle low", pulse_real, 0);
        fire(0);
        check(pulse_real === 1'b1, "R3 inverted active high", pulse_real, 1);
        measure(0, n, o);
        check(n == 3, "R3 inverted width", n, 3);
        cfg_invert = 0;
    endtask

    task automatic t_paced();
        int n; bit o;
        cfg_interval = 3; cfg_maxw = 1;
        do_reset();
        fire(0); measure(0, n, o);
        check(n == 9, "R4 paced width", n, 9);
    endtask

    task automatic t_queue();
        int n; bit o;
        cfg_interval = 2; cfg_maxw = 0;
        do_reset();
        @(negedge clk); req_real = 1;
        repeat (3) @(negedge clk);
        req_real = 0;
        for (int k = 0; k < 3; k++) begin
            measure(0, n, o);
            check(n == 2, "R5 queued pulse width", n, 2);
        end
        measure(0, n, o);
        check(n == -1, "R5 no extra pulse", n, -1);
        check(ovf_real == 0, "R5 no overflow at 3", ovf_real, 0);
    endtask

    task automatic t_overflow();
        cfg_interval = 8; cfg_maxw = 0;
        do_reset();
        @(negedge clk); req_real = 1;
        repeat (6) @(negedge clk);
        req_real = 0;
        check(ovf_real == 1, "R6 paced overflow", ovf_real, 1);
        check(ovf_react == 0, "R8 other flag", ovf_react, 0);
        repeat (200) @(negedge clk);
        check(ovf_real == 1, "R6 sticky", ovf_real, 1);
        cfg_interval = 0; cfg_maxw = 3;
        do_reset();
        fire(0);
        check(ovf_real == 0, "R6 no flag yet", ovf_real, 0);
        fire(0);
        check(ovf_real == 1, "R6 direct overflow", ovf_real, 1);
    endtask

    task automatic t_uncapped();
        int n, cnt; bit o;
        cfg_interval = 0; cfg_maxw = 8'hFF;
        do_reset();
        @(negedge clk); req_real = 1;
        @(negedge clk); req_real = 0;
        measure(0, n, o);
        check(n == 1, "R7 minimum width", n, 1);
        cnt = n;
        while (cnt < 20) begin
            if (sample_tick) cnt++;
            if (cnt < 20) @(negedge clk);
        end
        fire(0); measure(0, n, o);
        check(n == 10, "R7 half gap", n, 10);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_direct();
        t_polarity();
        t_paced();
        t_queue();
        t_overflow();
        t_uncapped();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule